// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the general-purpose register storage of a single-cycle processor datapath. It holds 32 words of 32 bits. Two read ports, each with its own 5-bit index, return operands at the same time. One write port takes a 5-bit index, a 32-bit word and an enable, and it stores results back into the array.

Reads are combinational. Each output follows its index and the stored contents with no clock edge in between. The write is committed on the falling clock edge. A result produced in the first half of a cycle can therefore be read back in the second half of the same cycle. Index 0 is a constant-zero location: it always reads as zero, and a write to it is accepted without any effect. An active-high reset, sampled on the same falling edge, clears the whole array.

Top module: `dual_rd_regfile`

## Requirements
- R1: The file holds 32 entries of 32 bits. An entry written at a nonzero index keeps its value until it is written again or reset.
- R2: Whenever either read index is 0, that port outputs 32'h0000_0000.
- R3: When `wr_en` is 1 and `wr_idx` is nonzero, `wr_data` is stored at `wr_idx` on the falling clock edge. A read of that index shows the old value before that edge and the new value after it, within the same cycle.
- R4: When `wr_en` is 0, no entry changes, whatever `wr_idx` and `wr_data` carry.
- R5: A write with `wr_en` = 1 and `wr_idx` = 0 changes no entry, and index 0 still reads as zero.
- R6: The two read ports are independent. They may address the same entry or different entries in the same cycle, and each returns its own entry.
- R7: A change of a read index changes that port's output with no clock edge in between.
- R8: `rst` = 1 at a falling clock edge clears every entry to zero, and this takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes and reset act on its falling edge |
| rst | input | 1 | Active-high synchronous reset, clears all entries |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Word to write |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Contents of entry `rd_idx_a` (zero for index 0) |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Contents of entry `rd_idx_b` (zero for index 0) |

## Verification
A write or reset applied just after a rising edge becomes visible at the read outputs only after the next falling edge, half a period later. Read-index changes take effect at once, with no edge at all. Each bench step drives its inputs 1 time unit after the rising edge. It samples once before the falling edge to confirm that the old contents still show, and again 2 units after the falling edge for the new contents. Combinational reads are checked 1 unit after the index changes, within one clock phase.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int RF_DEPTH = 32;
    localparam int RF_WIDTH = 32;
    localparam int RF_IDX_W = $clog2(RF_DEPTH);
    localparam int RF_NUM_RD = 2;

    typedef logic [RF_WIDTH-1:0] rf_word_t;
    typedef logic [RF_IDX_W-1:0] rf_idx_t;

    typedef struct packed {
        logic [RF_DEPTH-1:0][RF_WIDTH-1:0] regs;
    } rf_state_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int DEPTH = regfile_pkg::RF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [DEPTH-1:0] wr_sel
);
    // entry 0 is the constant-zero location and never receives a select
    assign wr_sel[0] = 1'b0;

    for (genvar i = 1; i < DEPTH; i++) begin : g_sel
        assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));
    end

    // R3
    wr_sel_onehot_chk: assert property (@(negedge clk) disable iff (rst)
        $onehot0(wr_sel));

    // R4
    wr_idle_sel_chk: assert property (@(negedge clk) disable iff (rst)
        !wr_en |-> (wr_sel == '0));

    // R5
    wr_zero_sel_chk: assert property (@(negedge clk) disable iff (rst)
        (wr_idx == '0) |-> (wr_sel == '0));
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH = regfile_pkg::RF_DEPTH,
    parameter int WIDTH = regfile_pkg::RF_WIDTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0] regs_q
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] regs;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.regs = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_sel[i]) begin
                    state_d.regs[i] = wr_data;
                end
            end
        end
    end

    // the array is clocked on the falling edge
    always_ff @(negedge clk) begin
        state_q <= state_d;
    end

    assign regs_q = state_q.regs;

    // R8
    reset_clear_chk: assert property (@(negedge clk)
        rst |=> (state_q.regs == '0));

    // R5
    zero_entry_chk: assert property (@(negedge clk) disable iff (rst)
        state_q.regs[0] == '0);

    for (genvar i = 1; i < DEPTH; i++) begin : g_chk
        // R3
        entry_load_chk: assert property (@(negedge clk) disable iff (rst)
            wr_sel[i] |=> (state_q.regs[i] == $past(wr_data)));
        // R1
        entry_hold_chk: assert property (@(negedge clk) disable iff (rst)
            !wr_sel[i] |=> $stable(state_q.regs[i]));
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DEPTH = regfile_pkg::RF_DEPTH,
    parameter int WIDTH = regfile_pkg::RF_WIDTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0][WIDTH-1:0] regs,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WIDTH-1:0]            rd_data
);
    always_comb begin
        if (rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = regs[rd_idx];
        end
    end

    // R2
    rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == '0) |-> (rd_data == '0));
endmodule

// File: rtl/dual_rd_regfile.sv
module dual_rd_regfile
    import regfile_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    parameter int WIDTH = RF_WIDTH,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NUM_RD = RF_NUM_RD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [WIDTH-1:0] rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [WIDTH-1:0] rd_data_b
);
    logic [DEPTH-1:0]            wr_sel;
    logic [DEPTH-1:0][WIDTH-1:0] regs_q;
    logic [IDX_W-1:0]            rd_idx_v  [NUM_RD];
    logic [WIDTH-1:0]            rd_data_v [NUM_RD];

    rf_wr_decode #(.DEPTH(DEPTH)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_sel (wr_sel)
    );

    rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    assign rd_idx_v[0] = rd_idx_a;
    assign rd_idx_v[1] = rd_idx_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_port (
            .clk     (clk),
            .rst     (rst),
            .regs    (regs_q),
            .rd_idx  (rd_idx_v[p]),
            .rd_data (rd_data_v[p])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];

    // R6
    same_index_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));
endmodule

// File: tb/dual_rd_regfile_tb.sv
module dual_rd_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic [4:0]  rd_idx_a;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_idx_b;
    logic [31:0] rd_data_b;

    int total = 0;
    int bad = 0;
    logic [31:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_rd_regfile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wi;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'hA5A5_0001, 32'h0},
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd5,  32'h0,         32'hA5A5_0001},
        '{1'b1, 5'd31, 32'h1234_5678, 5'd31, 5'd5,  32'h1234_5678, 32'hA5A5_0001},
        '{1'b0, 5'd31, 32'hDEAD_BEEF, 5'd31, 5'd31, 32'h1234_5678, 32'h1234_5678},
        '{1'b1, 5'd5,  32'h0000_00FF, 5'd5,  5'd31, 32'h0000_00FF, 32'h1234_5678},
        '{1'b1, 5'd1,  32'h8000_0000, 5'd1,  5'd2,  32'h8000_0000, 32'h0},
        '{1'b0, 5'd1,  32'h0,         5'd5,  5'd1,  32'h0000_00FF, 32'h8000_0000},
        '{1'b1, 5'd2,  32'hCAFE_F00D, 5'd2,  5'd2,  32'hCAFE_F00D, 32'hCAFE_F00D}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after a rising edge, then wait for the falling edge plus 2
    task automatic drive(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(posedge clk);
        #1;
        wr_en = we; wr_idx = wi; wr_data = wd; rd_idx_a = ra; rd_idx_b = rb;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx_a = '0; rd_idx_b = '0;
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;

        // reset state, both ports (R8, R2)
        drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd0);
        settle();
        check("R8 reset entry7", rd_data_a, 32'h0);
        check("R2 port b idx0", rd_data_b, 32'h0);

        // vector table (R1 R3 R4 R5 R6)
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].we, VECS[v].wi, VECS[v].wd, VECS[v].ra, VECS[v].rb);
            settle();
            check($sformatf("R6 vec%0d port a", v), rd_data_a, VECS[v].ea);
            check($sformatf("R6 vec%0d port b", v), rd_data_b, VECS[v].eb);
        end

        // R3: old value before falling edge, new value after it
        drive(1'b1, 5'd9, 32'h0BAD_F00D, 5'd9, 5'd9);
        #2;
        check("R3 before falling edge", rd_data_a, 32'h0);
        settle();
        check("R3 after falling edge", rd_data_b, 32'h0BAD_F00D);

        // R7: index change visible with no clock edge
        drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd2);
        #1;
        check("R7 initial a", rd_data_a, 32'h0BAD_F00D);
        rd_idx_a = 5'd31;
        #1;
        check("R7 after index change", rd_data_a, 32'h1234_5678);
        rd_idx_b = 5'd0;
        #1;
        check("R7 R2 index to zero", rd_data_b, 32'h0);

        // R5: write to index 0 leaves other entries and zero alone
        drive(1'b1, 5'd0, 32'h5555_AAAA, 5'd0, 5'd2);
        settle();
        check("R5 idx0 still zero", rd_data_a, 32'h0);
        check("R5 entry2 unchanged", rd_data_b, 32'hCAFE_F00D);

        // R4: disabled write with full data to each index leaves contents
        drive(1'b0, 5'd2, 32'h1111_1111, 5'd2, 5'd9);
        settle();
        check("R4 entry2 kept", rd_data_a, 32'hCAFE_F00D);
        check("R4 entry9 kept", rd_data_b, 32'h0BAD_F00D);

        // R1: sweep all nonzero entries, read back from both ports
        model[0] = 32'h0;
        for (int i = 1; i < 32; i++) begin
            model[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0101_0107);
            drive(1'b1, 5'(i), model[i], 5'd0, 5'd0);
            settle();
        end
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            #1;
            check($sformatf("R1 sweep a idx%0d", i), rd_data_a, model[i]);
            check($sformatf("R1 sweep b idx%0d", 31 - i), rd_data_b, model[31 - i]);
        end

        // R8: reset wins over a same-cycle write and clears the array
        drive(1'b1, 5'd4, 32'h7777_7777, 5'd4, 5'd17);
        rst = 1'b1;
        settle();
        check("R8 write blocked by reset", rd_data_a, 32'h0);
        check("R8 entry17 cleared", rd_data_b, 32'h0);
        drive(1'b0, 5'd0, 32'h0, 5'd31, 5'd1);
        rst = 1'b0;
        settle();
        check("R8 entry31 cleared", rd_data_a, 32'h0);
        check("R8 entry1 cleared", rd_data_b, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule